// File: doc/BRIEF.md
# Lockable Clock Channel Register Bank

This block holds the control words for a set of peripheral clock channels. Each word names the clock generator that feeds the channel, says whether the channel is on, and carries a sticky lock flag. Software reaches the words through a plain write port and a read port that returns data one cycle later. The decoded per-channel enable and generator index are driven straight to the clock distribution logic.

Once a channel's lock flag is set, its word is frozen. The block also raises a lock request for the generator that the channel names. The control register of that generator, which sits outside this block, must then refuse writes.

Two resets act on the bank. The power reset wipes every word and is the only way to release a lock. The user reset clears only the channels that are not locked.

Top module: `clkchan_bank`

## Requirements
- R1: The word for channel m (0 to NUM_CH-1) is reached at byte address 0x80 + 4*m. Any other address reaches no word: below 0x80, past the last channel, or with address bits 1:0 not 00. A write to such an address changes nothing, and a read from it returns 0.
- R2: The word has three fields. Bit 7 is the lock flag, bit 6 is the enable, and bits 3:0 hold the generator select. Bits 31:8, 5 and 4 are not stored and read as 0.
- R3: While a channel's lock flag is 1, every write to that channel is ignored and its fields keep their values.
- R4: A write that sets the lock flag also stores the enable and select it carries. Only later writes are blocked.
- R5: gen_lock_o[n], for n from 1 to NUM_GEN-1, is 1 exactly when some channel has its lock flag at 1 and its select equal to n.
- R6: gen_lock_o[0] is always 0, even when a locked channel selects generator 0.
- R7: Power reset clears the lock, enable and select of every channel, and the read data, on the next clock edge. After that, writes are accepted again.
- R8: User reset clears the enable and select of every unlocked channel. It leaves locked channels untouched and never changes a lock flag.
- R9: A select value of NUM_GEN (5) or above is stored as written. ch_gen_ok_o for that channel is 0, and such a value raises no generator lock. ch_gen_ok_o is 1 for select values below NUM_GEN.
- R10: rd_data_o shows, after the clock edge, the word that rd_addr_i addressed before that edge. Until that edge it holds its previous value.
- R11: When power reset and user reset are asserted together, the power reset action applies, and locked channels are cleared too.
- R12: ch_en_o[m] and ch_gen_o[4m+3:4m] follow the stored enable and select of channel m. They change on the same edge as the write that updates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power reset, synchronous, active high |
| usr_rst_i | input | 1 | User reset, synchronous, active high |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W (12) | Byte address of the write |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W (12) | Byte address of the read |
| rd_data_o | output | 32 | Read data, registered |
| ch_en_o | output | NUM_CH (48) | Per-channel enable |
| ch_gen_o | output | 4*NUM_CH (192) | Per-channel generator select, 4 bits per channel |
| ch_gen_ok_o | output | NUM_CH (48) | Per-channel flag, 1 when the select names an existing generator |
| gen_lock_o | output | NUM_GEN (5) | Per-generator lock request |

## Verification
The bench builds the bank with its default parameters: 48 channels, 5 generators, a 12-bit address and base 0x80. With these values it can reach the last channel at 0x13C and the first unmapped word just past it at 0x140, and it can probe a misaligned address inside the window. With 5 generators, select value 10 is out of range, and generator 3 is an in-range lock target that does not collide with generator 0. So the invalid-select path and the generator-0 exemption can be told apart on gen_lock_o.

// File: rtl/clkchan_pkg.sv
package clkchan_pkg;
   localparam int unsigned DATA_W  = 32;
   localparam int unsigned SEL_W   = 4;
   localparam int unsigned LOCK_B  = 7;
   localparam int unsigned EN_B    = 6;

   typedef struct packed {
      logic             lock;
      logic             en;
      logic [SEL_W-1:0] sel;
   } chan_word_t;

   function automatic logic [DATA_W-1:0] pack_word(chan_word_t w);
      logic [DATA_W-1:0] r;
      r = '0;
      r[LOCK_B]    = w.lock;
      r[EN_B]      = w.en;
      r[SEL_W-1:0] = w.sel;
      return r;
   endfunction
endpackage

// File: rtl/clkchan_decode.sv
module clkchan_decode #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned BASE_ADDR = 'h80,
   parameter int unsigned NUM_CH    = 48,
   localparam int unsigned CH_IW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic [CH_IW-1:0]  idx_o
);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] SPAN_V = ADDR_W'(NUM_CH * 4);

   logic [ADDR_W-1:0] off;

   always_comb begin
      off   = addr_i - BASE_V;
      hit_o = (addr_i >= BASE_V) && (off[1:0] == 2'b00) && (off < SPAN_V);
      idx_o = off[CH_IW+1:2];
   end
endmodule

// File: rtl/clkchan_reg.sv
module clkchan_reg
   import clkchan_pkg::*;
(
   input  logic       clk_i,
   input  logic       por_i,
   input  logic       usr_rst_i,
   input  logic       wr_i,
   input  chan_word_t wr_word_i,
   output chan_word_t word_o
);
   chan_word_t q;

   always_ff @(posedge clk_i) begin
      if (por_i) begin
         q <= '0;
      end else if (usr_rst_i) begin
         if (!q.lock) begin
            q.en  <= 1'b0;
            q.sel <= '0;
         end
      end else if (wr_i && !q.lock) begin
         q <= wr_word_i;
      end
   end

   assign word_o = q;
endmodule

// File: rtl/clkchan_genlock.sv
module clkchan_genlock
   import clkchan_pkg::*;
#(
   parameter int unsigned NUM_CH  = 48,
   parameter int unsigned NUM_GEN = 5
) (
   input  logic [NUM_CH-1:0]       lock_i,
   input  logic [NUM_CH*SEL_W-1:0] sel_i,
   output logic [NUM_GEN-1:0]      gen_lock_o
);
   assign gen_lock_o[0] = 1'b0;

   for (genvar n = 1; n < NUM_GEN; n++) begin : g_gen
      logic any;
      always_comb begin
         any = 1'b0;
         for (int c = 0; c < NUM_CH; c++) begin
            if (lock_i[c] && (sel_i[c*SEL_W +: SEL_W] == SEL_W'(n)))
               any = 1'b1;
         end
      end
      assign gen_lock_o[n] = any;
   end
endmodule

// File: rtl/clkchan_bank.sv
module clkchan_bank
   import clkchan_pkg::*;
#(
   parameter int unsigned NUM_CH    = 48,
   parameter int unsigned NUM_GEN   = 5,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned BASE_ADDR = 'h80
) (
   input  logic                    clk_i,
   input  logic                    por_i,
   input  logic                    usr_rst_i,
   input  logic                    wr_en_i,
   input  logic [ADDR_W-1:0]       wr_addr_i,
   input  logic [DATA_W-1:0]       wr_data_i,
   input  logic [ADDR_W-1:0]       rd_addr_i,
   output logic [DATA_W-1:0]       rd_data_o,
   output logic [NUM_CH-1:0]       ch_en_o,
   output logic [NUM_CH*SEL_W-1:0] ch_gen_o,
   output logic [NUM_CH-1:0]       ch_gen_ok_o,
   output logic [NUM_GEN-1:0]      gen_lock_o
);
   localparam int unsigned CH_IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 1 || NUM_CH > 256) begin : g_bad_ch
      $error("NUM_CH out of range");
   end
   if (NUM_GEN < 2 || NUM_GEN > (1 << SEL_W)) begin : g_bad_gen
      $error("NUM_GEN must fit the select field");
   end
   if (BASE_ADDR % 4 != 0 || BASE_ADDR + 4 * NUM_CH > (1 << ADDR_W)) begin : g_bad_map
      $error("register window does not fit the address space");
   end

   logic             wr_hit, rd_hit;
   logic [CH_IW-1:0] wr_idx, rd_idx;
   chan_word_t       wr_word;
   chan_word_t       words [NUM_CH];
   logic [NUM_CH-1:0] lock_vec;
   logic             unused_bits;

   clkchan_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_CH(NUM_CH)) u_wr_dec (
      .addr_i(wr_addr_i), .hit_o(wr_hit), .idx_o(wr_idx)
   );
   clkchan_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_CH(NUM_CH)) u_rd_dec (
      .addr_i(rd_addr_i), .hit_o(rd_hit), .idx_o(rd_idx)
   );

   assign wr_word.lock = wr_data_i[LOCK_B];
   assign wr_word.en   = wr_data_i[EN_B];
   assign wr_word.sel  = wr_data_i[SEL_W-1:0];
   assign unused_bits  = ^{wr_data_i[DATA_W-1:LOCK_B+1], wr_data_i[EN_B-1:SEL_W]};

   for (genvar m = 0; m < NUM_CH; m++) begin : g_ch
      logic wr_this;
      assign wr_this = wr_en_i && wr_hit && (wr_idx == CH_IW'(m));

      clkchan_reg u_reg (
         .clk_i(clk_i), .por_i(por_i), .usr_rst_i(usr_rst_i),
         .wr_i(wr_this), .wr_word_i(wr_word), .word_o(words[m])
      );

      assign lock_vec[m]                = words[m].lock;
      assign ch_en_o[m]                 = words[m].en;
      assign ch_gen_o[m*SEL_W +: SEL_W] = words[m].sel;
      assign ch_gen_ok_o[m]             = (words[m].sel < SEL_W'(NUM_GEN));
   end

   clkchan_genlock #(.NUM_CH(NUM_CH), .NUM_GEN(NUM_GEN)) u_genlock (
      .lock_i(lock_vec), .sel_i(ch_gen_o), .gen_lock_o(gen_lock_o)
   );

   logic [DATA_W-1:0] rd_next;
   always_comb begin
      rd_next = '0;
      for (int m = 0; m < NUM_CH; m++) begin
         if (rd_hit && rd_idx == CH_IW'(m)) rd_next = pack_word(words[m]);
      end
   end

   always_ff @(posedge clk_i) begin
      if (por_i) rd_data_o <= '0;
      else       rd_data_o <= rd_next;
   end
endmodule

// File: rtl/clkchan_bank_chk.sv
module clkchan_bank_chk #(
   parameter int unsigned NUM_CH  = 48,
   parameter int unsigned NUM_GEN = 5
) (
   input logic               clk_i,
   input logic               por_i,
   input logic               usr_rst_i,
   input logic [NUM_CH-1:0]  lock_vec,
   input logic [NUM_CH-1:0]  ch_en_o,
   input logic [NUM_GEN-1:0] gen_lock_o
);
   assert_lock_sticky_R3: assert property (@(posedge clk_i) disable iff (por_i)
      1'b1 |=> ((lock_vec & $past(lock_vec)) == $past(lock_vec)));

   assert_locked_en_hold_R3: assert property (@(posedge clk_i) disable iff (por_i)
      1'b1 |=> (((ch_en_o ^ $past(ch_en_o)) & $past(lock_vec)) == '0));

   assert_gen0_free_R6: assert property (@(posedge clk_i) disable iff (por_i)
      gen_lock_o[0] == 1'b0);

   assert_por_clears_R7: assert property (@(posedge clk_i)
      por_i |=> (lock_vec == '0 && ch_en_o == '0));

   assert_usr_keeps_lock_R8: assert property (@(posedge clk_i) disable iff (por_i)
      usr_rst_i |=> (lock_vec == $past(lock_vec)));

   assert_genlock_needs_lock_R5: assert property (@(posedge clk_i) disable iff (por_i)
      (gen_lock_o != '0) |-> (lock_vec != '0));
endmodule

bind clkchan_bank clkchan_bank_chk #(.NUM_CH(NUM_CH), .NUM_GEN(NUM_GEN)) u_chk (
   .clk_i(clk_i), .por_i(por_i), .usr_rst_i(usr_rst_i),
   .lock_vec(lock_vec), .ch_en_o(ch_en_o), .gen_lock_o(gen_lock_o)
);

// File: tb/clkchan_bank_test.sv
`timescale 1ns/1ps
module clkchan_bank_test;
   localparam int NCH = 48;
   localparam int NG  = 5;

   logic            clk_i = 1'b0;
   logic            por_i = 1'b1;
   logic            usr_rst_i = 1'b0;
   logic            wr_en_i = 1'b0;
   logic [11:0]     wr_addr_i = '0;
   logic [31:0]     wr_data_i = '0;
   logic [11:0]     rd_addr_i = '0;
   logic [31:0]     rd_data_o;
   logic [NCH-1:0]  ch_en_o;
   logic [NCH*4-1:0] ch_gen_o;
   logic [NCH-1:0]  ch_gen_ok_o;
   logic [NG-1:0]   gen_lock_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk_i = ~clk_i;

   clkchan_bank uut (
      .clk_i(clk_i), .por_i(por_i), .usr_rst_i(usr_rst_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
      .ch_en_o(ch_en_o), .ch_gen_o(ch_gen_o), .ch_gen_ok_o(ch_gen_ok_o),
      .gen_lock_o(gen_lock_o)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] ca(int m);
      return 12'(32'h80 + 4 * m);
   endfunction

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk_i);
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
      @(posedge clk_i); #1;
      wr_en_i = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
      @(negedge clk_i);
      rd_addr_i = a;
      @(posedge clk_i); #1;
      chk(req, rd_data_o, exp);
   endtask

   task automatic t_reset;
      chk("R7 enables after power reset", 32'(ch_en_o), 0);
      chk("R7 gen lock after power reset", 32'(gen_lock_o), 0);
      rd_chk("R7 ch0 after power reset", ca(0), 0);
      rd_chk("R7 ch47 after power reset", ca(47), 0);
   endtask

   task automatic t_map;
      wr(ca(0), 32'hFFFF_FF72);
      chk("R12 ch_en[0]", 32'(ch_en_o[0]), 1);
      chk("R12 ch_gen[0]", 32'(ch_gen_o[3:0]), 2);
      rd_chk("R2 unused bits read zero", ca(0), 32'h42);
      wr(ca(47), 32'h43);
      rd_chk("R1 last channel", ca(47), 32'h43);
      wr(12'h140, 32'h41);
      rd_chk("R1 past end reads zero", 12'h140, 0);
      rd_chk("R1 past end wrote nothing", ca(47), 32'h43);
      wr(12'h081, 32'h44);
      rd_chk("R1 misaligned wrote nothing", ca(0), 32'h42);
      wr(12'h07C, 32'h44);
      rd_chk("R1 below base wrote nothing", ca(0), 32'h42);
   endtask

   task automatic t_lock;
      wr(ca(5), 32'hC3);
      rd_chk("R4 lock write stores fields", ca(5), 32'hC3);
      chk("R5 generator 3 locked", 32'(gen_lock_o), 32'h08);
      wr(ca(5), 32'h01);
      rd_chk("R3 locked write ignored", ca(5), 32'hC3);
      chk("R3 locked enable held", 32'(ch_en_o[5]), 1);
   endtask

   task automatic t_gen0;
      wr(ca(6), 32'h80);
      rd_chk("R6 lock on gen0 stored", ca(6), 32'h80);
      chk("R6 generator 0 never locked", 32'(gen_lock_o), 32'h08);
   endtask

   task automatic t_invalid;
      wr(ca(7), 32'h8A);
      rd_chk("R9 out-of-range select stored", ca(7), 32'h8A);
      chk("R9 gen ok low", 32'(ch_gen_ok_o[7]), 0);
      chk("R9 gen ok high in range", 32'(ch_gen_ok_o[0]), 1);
      chk("R9 no lock raised", 32'(gen_lock_o), 32'h08);
   endtask

   task automatic t_usr;
      @(negedge clk_i); usr_rst_i = 1'b1;
      @(posedge clk_i); #1; usr_rst_i = 1'b0;
      chk("R8 unlocked enable cleared", 32'(ch_en_o[0]), 0);
      rd_chk("R8 unlocked ch0 cleared", ca(0), 0);
      rd_chk("R8 unlocked ch47 cleared", ca(47), 0);
      rd_chk("R8 locked ch5 kept", ca(5), 32'hC3);
      rd_chk("R8 locked ch7 kept", ca(7), 32'h8A);
      chk("R8 gen lock kept", 32'(gen_lock_o), 32'h08);
   endtask

   task automatic t_rdlat;
      rd_chk("R10 prime read", ca(0), 0);
      @(negedge clk_i);
      rd_addr_i = ca(5);
      #1;
      chk("R10 data not yet changed", rd_data_o, 0);
      @(posedge clk_i); #1;
      chk("R10 data after edge", rd_data_o, 32'hC3);
   endtask

   task automatic t_prio;
      @(negedge clk_i); por_i = 1'b1; usr_rst_i = 1'b1;
      @(posedge clk_i); #1; por_i = 1'b0; usr_rst_i = 1'b0;
      chk("R11 locks cleared under both resets", 32'(gen_lock_o), 0);
      rd_chk("R11 locked ch5 cleared", ca(5), 0);
      wr(ca(5), 32'h41);
      rd_chk("R7 write accepted after power reset", ca(5), 32'h41);
   endtask

   initial begin
      repeat (3) @(posedge clk_i);
      #1; por_i = 1'b0;
      t_reset();
      t_map();
      t_lock();
      t_gen0();
      t_invalid();
      t_usr();
      t_rdlat();
      t_prio();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #20000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule